// File: doc/BRIEF.md
# Performance Counter Enable Summary Decoder

This block keeps two performance-monitor control words and reduces them to a compact per-counter view. For six counters it reports which ones are currently counting completed instructions and which are counting cycles. It also gives a single flag that is high when any counter counts instructions. Downstream logic can read these summaries directly and does not need to decode event selects or freeze controls again.

Software loads either control word through a one-cycle write port. Control word A holds three freeze controls: a global freeze, a freeze for counters 1 to 4, and a freeze for counters 5 and 6. Control word B holds four 8-bit event-select fields, one for each of counters 1 to 4. Counter 5 is hard-wired to instructions and counter 6 to cycles. The summaries are registered and follow a write by one cycle.

Top module: `pmu_sum_decode`

## Requirements
- R1: After reset both masks and the any-instruction flag are zero. Control word A resets with its global freeze set, so they stay zero until a write occurs.
- R2: While the global freeze (control word A bit 0) is set, both masks are zero regardless of every other field.
- R3: Counters 1 to 4 contribute nothing while the low-group freeze (control word A bit 1) is set, or while control word B is zero.
- R4: Counter 1 is an instruction counter for select code 0x02 or 0xFE and a cycle counter for select code 0x1E or 0xF0. Its select field is control word B bits 31:24.
- R5: Counters 2 and 3 (fields at bits 23:16 and 15:8) count instructions only for 0x02 and cycles only for 0x1E. The codes 0xFE, 0xF0 and 0xFA leave them idle.
- R6: Counter 4 (field at bits 7:0) counts instructions for 0x02 or 0xFA and cycles for 0x1E.
- R7: Counter 5 always counts instructions and counter 6 always counts cycles, unless the high-group freeze (control word A bit 2) or the global freeze is set. The low-group freeze does not affect them.
- R8: Counter n drives bit n of each 7-bit mask. Bit 0 is always zero, and no bit is set in both masks at once.
- R9: The any-instruction flag equals the OR of all bits of the instruction mask.
- R10: A write with wr_sel low loads control word A and one with wr_sel high loads control word B on the write edge. The masks reflect the new value on the following clock edge, not on the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_sel | input | 1 | 0 selects control word A (freezes), 1 selects control word B (event selects) |
| wr_data | input | 32 | Write data |
| ins_mask | output | 7 | Per-counter instruction-counting mask, bit n = counter n |
| cyc_mask | output | 7 | Per-counter cycle-counting mask, bit n = counter n |
| ins_any | output | 1 | High when any counter counts instructions |

## Verification
The decode is driven with control word B filled uniformly with each accepted code (0x02, 0x1E), then with the lane-specific codes (0xFE, 0xF0, 0xFA) in every field. This separates counter 1's and counter 4's extra codes from lanes 2 and 3, which must ignore them. Each freeze control is applied alone and in combination against a busy select word, which shows which group each freeze masks and that the global freeze overrides both groups. A zero select word and a mixed word with a different code in every field show the nonzero gate and confirm that each field maps to its own mask bit. The write-to-mask latency is observed in the cycle just after the write edge and in the cycle after that.

// File: rtl/pmu_sum_pkg.sv
package pmu_sum_pkg;
   localparam int NUM_CTR = 6;
   localparam int MASK_W  = NUM_CTR + 1;
   localparam int SEL_W   = 8;

   typedef logic [MASK_W-1:0] mask_t;
   typedef logic [SEL_W-1:0]  evsel_t;

   localparam evsel_t EV_INSN      = 8'h02;
   localparam evsel_t EV_CYCLE     = 8'h1E;
   localparam evsel_t EV_INSN_C1   = 8'hFE;
   localparam evsel_t EV_CYCLE_C1  = 8'hF0;
   localparam evsel_t EV_INSN_RUN  = 8'hFA;
endpackage

// File: rtl/pmu_sum_ctl.sv
module pmu_sum_ctl #(
   parameter int          DATA_W   = 32,
   parameter logic [31:0] CTLA_RST = 32'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ctla_q,
   output logic [DATA_W-1:0] ctlb_q
);
   if (DATA_W > 32) begin : g_bad_width
      $error("pmu_sum_ctl: DATA_W above 32 not supported");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctla_q <= CTLA_RST[DATA_W-1:0];
         ctlb_q <= '0;
      end else if (wr_en) begin
         if (wr_sel) ctlb_q <= wr_data;
         else        ctla_q <= wr_data;
      end
   end
endmodule

// File: rtl/pmu_sum_lane.sv
module pmu_sum_lane
   import pmu_sum_pkg::*;
#(
   parameter int LANE = 1
) (
   input  evsel_t sel,
   input  logic   enable,
   output logic   ins_hit,
   output logic   cyc_hit
);
   if (LANE < 1 || LANE > 4) begin : g_bad_lane
      $error("pmu_sum_lane: LANE must be 1..4");
   end

   if (LANE == 1) begin : g_lane1
      assign ins_hit = enable && (sel == EV_INSN || sel == EV_INSN_C1);
      assign cyc_hit = enable && (sel == EV_CYCLE || sel == EV_CYCLE_C1);
   end else if (LANE == 4) begin : g_lane4
      assign ins_hit = enable && (sel == EV_INSN || sel == EV_INSN_RUN);
      assign cyc_hit = enable && (sel == EV_CYCLE);
   end else begin : g_plain
      assign ins_hit = enable && (sel == EV_INSN);
      assign cyc_hit = enable && (sel == EV_CYCLE);
   end
endmodule

// File: rtl/pmu_sum_decode.sv
module pmu_sum_decode
   import pmu_sum_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int FRZ_ALL_BIT = 0,
   parameter int FRZ_LO_BIT  = 1,
   parameter int FRZ_HI_BIT  = 2,
   parameter int SEL1_LSB    = 24,
   parameter int SEL2_LSB    = 16,
   parameter int SEL3_LSB    = 8,
   parameter int SEL4_LSB    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [MASK_W-1:0] ins_mask,
   output logic [MASK_W-1:0] cyc_mask,
   output logic              ins_any
);
   localparam logic [31:0] CTLA_RST = 32'(1) << FRZ_ALL_BIT;
   localparam int          LO_CTRS  = 4;

   function automatic int lsb_of(input int lane);
      case (lane)
         1:       return SEL1_LSB;
         2:       return SEL2_LSB;
         3:       return SEL3_LSB;
         default: return SEL4_LSB;
      endcase
   endfunction

   if (FRZ_ALL_BIT >= DATA_W || FRZ_LO_BIT >= DATA_W || FRZ_HI_BIT >= DATA_W) begin : g_bad_frz
      $error("pmu_sum_decode: freeze bit outside control word");
   end
   if (FRZ_ALL_BIT == FRZ_LO_BIT || FRZ_ALL_BIT == FRZ_HI_BIT || FRZ_LO_BIT == FRZ_HI_BIT) begin : g_dup_frz
      $error("pmu_sum_decode: freeze bits must be distinct");
   end

   logic [DATA_W-1:0] ctla_q, ctlb_q;

   pmu_sum_ctl #(.DATA_W(DATA_W), .CTLA_RST(CTLA_RST)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .ctla_q  (ctla_q),
      .ctlb_q  (ctlb_q)
   );

   logic frz_all, frz_lo, frz_hi, lo_en, hi_en;
   assign frz_all = ctla_q[FRZ_ALL_BIT];
   assign frz_lo  = ctla_q[FRZ_LO_BIT];
   assign frz_hi  = ctla_q[FRZ_HI_BIT];
   assign lo_en   = !frz_all && !frz_lo && (ctlb_q != '0);
   assign hi_en   = !frz_all && !frz_hi;

   logic [LO_CTRS:1] lo_ins, lo_cyc;

   for (genvar l = 1; l <= LO_CTRS; l++) begin : g_lane
      localparam int LSB = lsb_of(l);
      if (LSB + SEL_W > DATA_W) begin : g_bad_field
         $error("pmu_sum_decode: select field outside control word");
      end
      pmu_sum_lane #(.LANE(l)) u_lane (
         .sel     (ctlb_q[LSB +: SEL_W]),
         .enable  (lo_en),
         .ins_hit (lo_ins[l]),
         .cyc_hit (lo_cyc[l])
      );
   end

   mask_t ins_nxt, cyc_nxt;
   always_comb begin
      ins_nxt = '0;
      cyc_nxt = '0;
      ins_nxt[LO_CTRS:1] = lo_ins;
      cyc_nxt[LO_CTRS:1] = lo_cyc;
      ins_nxt[5] = hi_en;
      cyc_nxt[6] = hi_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ins_mask <= '0;
         cyc_mask <= '0;
         ins_any  <= 1'b0;
      end else begin
         ins_mask <= ins_nxt;
         cyc_mask <= cyc_nxt;
         ins_any  <= |ins_nxt;
      end
   end

   // R2: global freeze empties both masks one edge later
   p_freeze_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frz_all |=> (ins_mask == '0 && cyc_mask == '0));

   // R3: low-group freeze silences counters 1 to 4
   p_freeze_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frz_lo |=> (ins_mask[4:1] == '0 && cyc_mask[4:1] == '0));

   // R7: high-group freeze silences counters 5 and 6
   p_freeze_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frz_hi |=> (!ins_mask[5] && !cyc_mask[6]));

   // R8: a counter never appears in both masks, and bit 0 stays clear
   p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ins_mask & cyc_mask) == '0) && !ins_mask[0] && !cyc_mask[0]);

   // R9: summary flag matches the instruction mask
   p_any_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ins_any == (ins_mask != '0));
endmodule

// File: tb/pmu_sum_decode_test.sv
`timescale 1ns/1ps
module pmu_sum_decode_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic [6:0]  ins_mask, cyc_mask;
   logic        ins_any;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [31:0] sh_a = 32'h1;
   logic [31:0] sh_b = 32'h0;

   always #4 clk = ~clk;

   pmu_sum_decode uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ins_mask(ins_mask), .cyc_mask(cyc_mask),
      .ins_any(ins_any)
   );

   function automatic logic [13:0] model(input logic [31:0] a, input logic [31:0] b);
      logic [6:0] im, cm;
      logic [7:0] s;
      im = '0; cm = '0;
      if (!a[0]) begin
         if (!a[1] && b != 0) begin
            s = b[31:24];
            im[1] = (s == 8'h02 || s == 8'hFE);
            cm[1] = (s == 8'h1E || s == 8'hF0);
            s = b[23:16];
            im[2] = (s == 8'h02); cm[2] = (s == 8'h1E);
            s = b[15:8];
            im[3] = (s == 8'h02); cm[3] = (s == 8'h1E);
            s = b[7:0];
            im[4] = (s == 8'h02 || s == 8'hFA);
            cm[4] = (s == 8'h1E);
         end
         if (!a[2]) begin
            im[5] = 1'b1; cm[6] = 1'b1;
         end
      end
      return {im, cm};
   endfunction

   task automatic chk(input string req, input logic [6:0] ei, input logic [6:0] ec);
      n_chk++;
      if (ins_mask !== ei || cyc_mask !== ec || ins_any !== (ei != 0)) begin
         n_bad++;
         $display("FAIL %s: ins=%h cyc=%h any=%b expected ins=%h cyc=%h any=%b",
                  req, ins_mask, cyc_mask, ins_any, ei, ec, (ei != 0));
      end
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (sel) sh_b = d; else sh_a = d;
   endtask

   task automatic settle_chk(input string req);
      logic [13:0] e;
      @(negedge clk);
      e = model(sh_a, sh_b);
      chk(req, e[13:7], e[6:0]);
   endtask

   task automatic t_reset;
      chk("R1 reset", 7'h00, 7'h00);
      repeat (3) @(negedge clk);
      chk("R1 idle after reset", 7'h00, 7'h00);
   endtask

   task automatic t_global_freeze;
      wr(1'b1, 32'h0202_1E02);
      settle_chk("R2 frozen with busy selects");
      chk("R2 explicit zero", 7'h00, 7'h00);
      wr(1'b0, 32'h0000_0007);
      settle_chk("R2 all freezes set");
   endtask

   task automatic t_insn_codes;
      wr(1'b0, 32'h0);
      wr(1'b1, 32'h0202_0202);
      settle_chk("R4 R5 R6 all lanes 0x02");
      chk("R8 bit map insn", 7'h3E, 7'h40);
      wr(1'b1, 32'h1E1E_1E1E);
      settle_chk("R4 R5 R6 all lanes 0x1E");
      chk("R8 bit map cycles", 7'h20, 7'h5E);
   endtask

   task automatic t_special_codes;
      wr(1'b1, 32'hFEFE_FEFE);
      settle_chk("R4 R5 code 0xFE");
      chk("R5 0xFE only counter 1", 7'h22, 7'h40);
      wr(1'b1, 32'hF0F0_F0F0);
      settle_chk("R4 R5 code 0xF0");
      chk("R5 0xF0 only counter 1", 7'h20, 7'h42);
      wr(1'b1, 32'hFAFA_FAFA);
      settle_chk("R6 R5 code 0xFA");
      chk("R6 0xFA only counter 4", 7'h30, 7'h40);
      wr(1'b1, 32'hF01E_02FA);
      settle_chk("R8 mixed fields");
      chk("R8 mixed fields explicit", 7'h38, 7'h46);
   endtask

   task automatic t_group_freeze;
      wr(1'b0, 32'h0000_0002);
      settle_chk("R3 low freeze");
      chk("R7 low freeze keeps 5/6", 7'h20, 7'h40);
      wr(1'b0, 32'h0000_0004);
      settle_chk("R7 high freeze");
      chk("R7 high freeze explicit", 7'h18, 7'h06);
      wr(1'b0, 32'h0000_0006);
      settle_chk("R9 both groups frozen");
      chk("R9 flag low", 7'h00, 7'h00);
      wr(1'b0, 32'h0000_0000);
      wr(1'b1, 32'h0);
      settle_chk("R3 zero select word");
      chk("R3 zero select explicit", 7'h20, 7'h40);
      wr(1'b0, 32'h0000_0004);
      settle_chk("R9 zero selects high freeze");
   endtask

   task automatic t_latency;
      logic [13:0] eo;
      eo = model(sh_a, sh_b);
      wr(1'b1, 32'h0202_0202);
      chk("R10 unchanged right after write edge", eo[13:7], eo[6:0]);
      settle_chk("R10 updated one edge later");
      wr(1'b0, 32'h0000_0001);
      chk("R10 freeze not yet visible", 7'h1E, 7'h00);
      settle_chk("R10 freeze visible");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_global_freeze();
      t_insn_codes();
      t_special_codes();
      t_group_freeze();
      t_latency();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule